// File: doc/BRIEF.md
# Two-Stage Compound Quotient Datapath

This block evaluates a fixed unsigned expression on four operands every clock cycle: three times the first operand plus the product of the second and third, integer-divided by the fourth, then increased by the third operand and a constant of five. The operands and the result travel through two register stages. A new operand set is accepted on every cycle, and each result leaves exactly two cycles after its operands went in. No handshake exists and nothing can stall the pipeline.

A qualifier bit runs next to the data. It marks the cycles in which the result belongs to a real request. A second flag reports a zero divisor in the same cycle as the result it affects. The first stage forms the weighted sum at full precision. The second stage performs the division and the final addition. Reset is synchronous and active-low.

Top module: `expr_pipe`

## Requirements
- R1: With a nonzero divisor, `result` equals floor((3*A + B*C) / D) + C + 5, taken modulo 2^OUT_W, on unsigned values.
- R2: The result for an operand set is on `result` exactly two rising edges after the edge that samples it. A different operand set may be presented on every cycle.
- R3: `out_valid` equals the `in_valid` sampled two rising edges earlier.
- R4: With a zero divisor, the quotient term becomes OUT_W ones. `result` is then (2^OUT_W - 1 + C + 5) modulo 2^OUT_W, and `div_zero` is 1 in the same cycle as that result.
- R5: `div_zero` is 0 for every result whose divisor was nonzero.
- R6: A rising edge with `rst_n` low sets `out_valid`, `div_zero` and `result` to 0 for the next cycle and drops every valid mark already in flight.
- R7: At the default widths, A=1, B=2, C=3, D=4 gives 0x0000000A, and A=1, B=3, C=5, D=7 gives 0x0000000C.
- R8: The arithmetic does not depend on `in_valid`. Operands presented with `in_valid` low still produce the R1 or R4 value two cycles later, with `out_valid` low.
- R9: No intermediate value overflows. With all four operands at 0xFFFF at the default widths, the result is 0x00020006.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operand set of this cycle as a request |
| op_a | input | OP_W (16) | Operand weighted by three |
| op_b | input | OP_W (16) | First factor of the product |
| op_c | input | OP_W (16) | Second factor of the product, also added after the divide |
| op_d | input | OP_W (16) | Divisor |
| out_valid | output | 1 | Qualifier of `result`, delayed two cycles |
| result | output | OUT_W (32) | Computed value |
| div_zero | output | 1 | The divisor of this result was zero |

## Verification
A reduced instance with 4-bit operands and an 8-bit result receives all 65536 operand combinations on back-to-back cycles. This exercises every remainder, every zero divisor and every wrap of the final sum, and because a new set arrives each cycle, an error of one cycle in the latency shows up immediately. A full-width instance runs the two stated vectors, the all-ones extreme that exposes any narrow intermediate, and the combinations of 0, 1, 0x8000 and 0xFFFF. These catch carry and truncation faults that small operands cannot show. A repeating valid pattern with one low cycle in three separates the qualifier path from the data path, and a single reset pulse in the middle of the stream shows that in-flight marks are discarded.

// File: rtl/expr_pkg.sv
// Shared constants and width helpers for the compound quotient datapath.
// Assumes unsigned operands throughout.
package expr_pkg;

    // Number of register stages between operands and result.
    localparam int unsigned EXPR_LAT = 2;

    // Width that holds 3*A + B*C for OP_W-bit operands without overflow.
    function automatic int sum_width(input int op_w);
        return 2 * op_w + 1;
    endfunction

endpackage

// File: rtl/expr_mac_stage.sv
// Stage one: forms 3*A + B*C at full precision and registers it together
// with C, D and the valid mark. Assumes unsigned operands; 3*A is built as
// a shift plus an add rather than a second multiplier.
module expr_mac_stage #(
    parameter int OP_W  = 16,
    parameter int SUM_W = expr_pkg::sum_width(OP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [OP_W-1:0]  op_c,
    input  logic [OP_W-1:0]  op_d,
    output logic             s1_valid,
    output logic [SUM_W-1:0] s1_sum,
    output logic [OP_W-1:0]  s1_c,
    output logic [OP_W-1:0]  s1_d
);

    logic [SUM_W-1:0] triple_a;
    logic [SUM_W-1:0] prod_bc;
    logic [SUM_W-1:0] sum_nxt;

    // Purpose: widen the operands and form the weighted sum.
    always_comb begin
        triple_a = (SUM_W'(op_a) << 1) + SUM_W'(op_a);
        prod_bc  = SUM_W'(op_b) * SUM_W'(op_c);
        sum_nxt  = triple_a + prod_bc;
    end

    // Purpose: register the sum, the pass-through operands and the mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sum   <= '0;
            s1_c     <= '0;
            s1_d     <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sum   <= sum_nxt;
            s1_c     <= op_c;
            s1_d     <= op_d;
        end
    end

endmodule

// File: rtl/expr_divu.sv
// Unrolled restoring divider, purely combinational. There is one
// compare-and-subtract row per numerator bit, from the most significant bit
// down. Assumes unsigned values. A zero divisor yields a quotient of all
// ones; the caller overrides that case anyway.
module expr_divu #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 16
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo
);

    logic [DEN_W-1:0] rem [0:NUM_W];

    assign rem[0] = '0;

    for (genvar i = 0; i < NUM_W; i++) begin : g_row
        logic [DEN_W:0] trial;
        logic [DEN_W:0] diff;
        logic           take;

        // Bring down the next numerator bit and try to subtract the divisor.
        assign trial = {rem[i], num[NUM_W-1-i]};
        assign diff  = trial - {1'b0, den};
        assign take  = (trial >= {1'b0, den});

        assign rem[i+1]         = take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        assign quo[NUM_W-1-i]   = take;
    end

endmodule

// File: rtl/expr_div_stage.sv
// Stage two: divides the registered sum by D, forces the quotient term to
// all ones for a zero divisor, adds C and the constant offset, and registers
// the result, the valid mark and the zero-divisor flag. The result wraps
// modulo 2^OUT_W.
module expr_div_stage #(
    parameter int OP_W   = 16,
    parameter int OUT_W  = 32,
    parameter int OFFSET = 5,
    parameter int SUM_W  = expr_pkg::sum_width(OP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [SUM_W-1:0] s1_sum,
    input  logic [OP_W-1:0]  s1_c,
    input  logic [OP_W-1:0]  s1_d,
    output logic             s2_valid,
    output logic [OUT_W-1:0] s2_result,
    output logic             s2_dz
);

    logic [SUM_W-1:0] quo_full;
    logic [OUT_W-1:0] quo_term;
    logic [OUT_W-1:0] res_nxt;
    logic             dz_nxt;

    expr_divu #(
        .NUM_W (SUM_W),
        .DEN_W (OP_W)
    ) u_divu (
        .num (s1_sum),
        .den (s1_d),
        .quo (quo_full)
    );

    // Purpose: select the quotient term and form the final sum.
    always_comb begin
        dz_nxt   = (s1_d == '0);
        quo_term = dz_nxt ? '1 : OUT_W'(quo_full);
        res_nxt  = quo_term + OUT_W'(s1_c) + OUT_W'(OFFSET);
    end

    // Purpose: register the result, its mark and the zero-divisor flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_result <= '0;
            s2_dz     <= 1'b0;
        end else begin
            s2_valid  <= s1_valid;
            s2_result <= res_nxt;
            s2_dz     <= dz_nxt;
        end
    end

endmodule

// File: rtl/expr_pipe.sv
// Top of the compound quotient datapath: floor((3A + B*C) / D) + C + 5 at
// one operand set per cycle with a fixed latency of two cycles. Synchronous
// active-low reset. No handshake and no stall.
module expr_pipe #(
    parameter int OP_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [OP_W-1:0]  op_c,
    input  logic [OP_W-1:0]  op_d,
    output logic             out_valid,
    output logic [OUT_W-1:0] result,
    output logic             div_zero
);

    localparam int SUM_W = expr_pkg::sum_width(OP_W);

    logic             s1_valid;
    logic [SUM_W-1:0] s1_sum;
    logic [OP_W-1:0]  s1_c;
    logic [OP_W-1:0]  s1_d;

    expr_mac_stage #(
        .OP_W  (OP_W),
        .SUM_W (SUM_W)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .op_d     (op_d),
        .s1_valid (s1_valid),
        .s1_sum   (s1_sum),
        .s1_c     (s1_c),
        .s1_d     (s1_d)
    );

    expr_div_stage #(
        .OP_W   (OP_W),
        .OUT_W  (OUT_W),
        .OFFSET (5),
        .SUM_W  (SUM_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_sum    (s1_sum),
        .s1_c      (s1_c),
        .s1_d      (s1_d),
        .s2_valid  (out_valid),
        .s2_result (result),
        .s2_dz     (div_zero)
    );

endmodule

// File: rtl/expr_pipe_chk.sv
// Timing checker for expr_pipe, attached by bind. It counts the edges since
// reset so that no property looks past the reset boundary.
module expr_pipe_chk #(
    parameter int OP_W  = 16,
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [OP_W-1:0]  op_c,
    input logic [OP_W-1:0]  op_d,
    input logic             out_valid,
    input logic [OUT_W-1:0] result,
    input logic             div_zero
);

    logic [1:0] since_rst;

    // Purpose: saturating count of edges with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R3: the qualifier arrives two cycles after its request.
    p_valid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R4 and R5: the flag follows the divisor from two cycles earlier.
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (div_zero == ($past(op_d, 2) == '0)));

    // R2: the same operands on two consecutive cycles give a steady result.
    p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) &&
         ($past(op_a, 2) == $past(op_a, 3)) && ($past(op_b, 2) == $past(op_b, 3)) &&
         ($past(op_c, 2) == $past(op_c, 3)) && ($past(op_d, 2) == $past(op_d, 3)))
        |-> (result == $past(result)));

    // R6: a reset edge clears every output on the next cycle.
    p_reset_clear_r6: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !div_zero && (result == '0)));

endmodule

bind expr_pipe expr_pipe_chk #(
    .OP_W  (OP_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .op_d      (op_d),
    .out_valid (out_valid),
    .result    (result),
    .div_zero  (div_zero)
);

// File: tb/expr_pipe_test.sv
// Bench: the full-width instance gets directed and corner vectors, and the
// 4/8-bit instance gets an exhaustive sweep. Both are driven on back-to-back
// cycles and checked two cycles later.
module expr_pipe_test;

    typedef struct {
        longint unsigned o;
        bit              v;
        bit              dz;
        bit              chk;
        string           tag_o;
        string           tag_dz;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;

    logic [15:0] a16 = '0, b16 = '0, c16 = '0, d16 = '0;
    logic        ov16, dz16;
    logic [31:0] r16;

    logic [3:0]  a4 = '0, b4 = '0, c4 = '0, d4 = '0;
    logic        ov4, dz4;
    logic [7:0]  r4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t hb0, hb1, hs0, hs1;

    always #4 clk = ~clk;

    expr_pipe #(.OP_W(16), .OUT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(a16), .op_b(b16), .op_c(c16), .op_d(d16),
        .out_valid(ov16), .result(r16), .div_zero(dz16)
    );

    expr_pipe #(.OP_W(4), .OUT_W(8)) uut_small (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(a4), .op_b(b4), .op_c(c4), .op_d(d4),
        .out_valid(ov4), .result(r4), .div_zero(dz4)
    );

    function automatic longint unsigned model(longint unsigned a, longint unsigned b,
                                              longint unsigned c, longint unsigned d,
                                              int ow);
        longint unsigned mask = (64'd1 << ow) - 1;
        longint unsigned q    = (d == 0) ? mask : (3 * a + b * c) / d;
        return (q + c + 5) & mask;
    endfunction

    function automatic logic [15:0] corner(input logic [1:0] s);
        case (s)
            2'd0:    return 16'h0000;
            2'd1:    return 16'h0001;
            2'd2:    return 16'h8000;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic exp_t reset_exp();
        exp_t e;
        e.o = 0; e.v = 1'b0; e.dz = 1'b0; e.chk = 1'b1;
        e.tag_o = "R6"; e.tag_dz = "R6";
        return e;
    endfunction

    function automatic exp_t idle_exp();
        exp_t e;
        e.o = 0; e.v = 1'b0; e.dz = 1'b0; e.chk = 1'b0;
        e.tag_o = "R6"; e.tag_dz = "R6";
        return e;
    endfunction

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string who, input exp_t e, input longint unsigned r,
                           input bit v, input bit dz);
        check(e.chk ? e.tag_o : "R3", {who, " out_valid"}, 64'(v), 64'(e.v));
        if (e.chk) begin
            check(e.tag_o,  {who, " result"},   r,       e.o);
            check(e.tag_dz, {who, " div_zero"}, 64'(dz), 64'(e.dz));
        end
    endtask

    // One cycle: check what is due, then drive the next operands.
    task automatic step(input bit rst, input int k, input bit vld);
        logic [15:0] sel;
        exp_t eb, es;
        @(negedge clk);
        compare("wide",  hb1, 64'(r16), ov16, dz16);
        compare("small", hs1, 64'(r4),  ov4,  dz4);

        rst_n    = !rst;
        in_valid = vld;

        if (k == 0)      begin a16 = 16'd1; b16 = 16'd2; c16 = 16'd3; d16 = 16'd4; end
        else if (k == 1) begin a16 = 16'd1; b16 = 16'd3; c16 = 16'd5; d16 = 16'd7; end
        else if (k == 2) begin a16 = '1; b16 = '1; c16 = '1; d16 = '1; end
        else begin
            sel = 16'(k);
            a16 = corner(sel[1:0]); b16 = corner(sel[3:2]);
            c16 = corner(sel[5:4]); d16 = corner(sel[7:6]);
        end
        sel = 16'(k);
        a4 = sel[3:0]; b4 = sel[7:4]; c4 = sel[11:8]; d4 = sel[15:12];

        eb.o   = model(64'(a16), 64'(b16), 64'(c16), 64'(d16), 32);
        eb.v   = vld; eb.dz = (d16 == 0); eb.chk = 1'b1;
        eb.tag_dz = eb.dz ? "R4" : "R5";
        if (k < 2)          eb.tag_o = "R7";
        else if (k == 2)    eb.tag_o = "R9";
        else if (eb.dz)     eb.tag_o = "R4";
        else if (!vld)      eb.tag_o = "R8";
        else                eb.tag_o = "R1/R2";
        if (k == 2 && eb.o != 64'h20006) begin
            fails++;
            $display("FAIL R9 model: actual 0x%0h expected 0x20006", eb.o);
        end

        es.o   = model(64'(a4), 64'(b4), 64'(c4), 64'(d4), 8);
        es.v   = vld; es.dz = (d4 == 0); es.chk = 1'b1;
        es.tag_dz = es.dz ? "R4" : "R5";
        es.tag_o  = es.dz ? "R4" : (!vld ? "R8" : "R1/R2");

        if (rst) begin
            hb1 = reset_exp(); hb0 = idle_exp();
            hs1 = reset_exp(); hs0 = idle_exp();
        end else begin
            hb1 = hb0; hb0 = eb;
            hs1 = hs0; hs0 = es;
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        hb1 = reset_exp(); hb0 = idle_exp();
        hs1 = reset_exp(); hs0 = idle_exp();
        for (int i = 0; i < 4; i++) step(1'b1, 0, 1'b1);
        for (int k = 0; k < 65536; k++) begin
            // R6: one reset pulse mid-stream while requests are flowing.
            step(k == 30000, k, (k % 3) != 0);
        end
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule